// File: doc/BRIEF.md
# Implicit-GEMM Convolution Address Generator

This block produces the activation-tensor byte addresses needed to run a 2-D convolution as a matrix product, without ever materialising the unrolled activation matrix. A tile is launched with a single start command that carries a linear output-row index. The block takes that row and the `ROWS - 1` rows after it, and splits each into batch, output row and output column. It then walks the filter window and the channel intervals, and emits one access per cycle until every channel interval has been covered.

Each access carries a signed byte address and a zero-fill flag. The flag tells the consumer that the element lies outside the tensor (padding, a channel past the end, or a row past the end of the batch) and must be read as zero. The address still advances along the same affine path, so the pointer stays correct for the in-bounds positions that follow.

When the filter position changes, the address is not recomputed. The block adds one entry of a three-entry byte-delta table that software loads with the other configuration fields. The entry is chosen by which loop counter wrapped. Separate height and width offsets are tracked alongside the address, and they drive the bounds predicate.

Top module: `igc_addr_gen`

## Requirements
- R1: After reset, `acc_vld_o`, `acc_zero_o`, `busy_o` and `done_o` are all low, and no access is emitted until a start is accepted.
- R2: Row slot j (0 ≤ j < ROWS) of a tile uses output index i = `start_row_i` + j. The index splits as n = i / (P·Q), p = (i mod P·Q) / Q and q = (i mod P·Q) mod Q.
- R3: For each filter position, ROWS·ACC_C accesses are emitted, with the channel-chunk index k varying fastest and the row slot next. Positions advance with s fastest, then r, then the channel base c. The channel base starts at 0 and grows by VEC·ACC_C·`cfg_split_i` each time both s and r wrap.
- R4: The address of an access is `cfg_base_i` + (((n·H + h)·W + w)·C + ch)·`cfg_elem_bytes_i`, where ch = c + k·VEC. The result is a signed value, so padded positions may give addresses below the base.
- R5: With `cfg_conv_i` = 0, h = p·stride_h − pad_h + r·dil_h and w = q·stride_w − pad_w + s·dil_w. With `cfg_conv_i` = 1, r is replaced by R−1−r and s by S−1−s.
- R6: `acc_zero_o` is high on an access exactly when h ∉ [0, H), or w ∉ [0, W), or ch ≥ C, or n ≥ N. It is never high without `acc_vld_o`.
- R7: At the first access of a new filter position, the address of row slot 0 with chunk 0 equals the same access at the previous position plus a table entry. The entry is `cfg_delta_s_i` when only s moved, `cfg_delta_r_i` when s wrapped and r moved, and `cfg_delta_c_i` when both wrapped and c moved.
- R8: Once the step after the last position would bring c to C or beyond, the cycle following the last access has `done_o` high for exactly one cycle, with `busy_o` and `acc_vld_o` low.
- R9: A start seen while idle is accepted, and `busy_o` is high from the next cycle on. A start seen while busy is ignored and leaves the access stream unchanged.
- R10: `acc_vld_o` rises only in the cycle after an accepted start. From then on it stays high every cycle until the last access of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_n_i | input | DIM_W | Batch count N |
| cfg_h_i | input | DIM_W | Input height H |
| cfg_w_i | input | DIM_W | Input width W |
| cfg_c_i | input | DIM_W | Channel count C |
| cfg_p_i | input | DIM_W | Output height P |
| cfg_q_i | input | DIM_W | Output width Q |
| cfg_r_i | input | DIM_W | Filter height R |
| cfg_s_i | input | DIM_W | Filter width S |
| cfg_stride_h_i | input | DIM_W | Vertical stride |
| cfg_stride_w_i | input | DIM_W | Horizontal stride |
| cfg_pad_h_i | input | DIM_W | Top padding |
| cfg_pad_w_i | input | DIM_W | Left padding |
| cfg_dil_h_i | input | DIM_W | Vertical dilation |
| cfg_dil_w_i | input | DIM_W | Horizontal dilation |
| cfg_split_i | input | DIM_W | Reduction slice count multiplying the channel step |
| cfg_elem_bytes_i | input | DIM_W | Bytes per element |
| cfg_conv_i | input | 1 | 0: cross-correlation, 1: flipped-filter convolution |
| cfg_base_i | input | ADDR_W | Byte address of element (0,0,0,0) |
| cfg_delta_s_i | input | ADDR_W | Byte delta when only s advances |
| cfg_delta_r_i | input | ADDR_W | Byte delta when s wraps and r advances |
| cfg_delta_c_i | input | ADDR_W | Byte delta when s and r wrap and c advances |
| start_i | input | 1 | Start a tile |
| start_row_i | input | IDX_W | Linear output-row index of row slot 0 |
| acc_vld_o | output | 1 | An access is presented this cycle |
| acc_addr_o | output | ADDR_W | Signed byte address of the access |
| acc_zero_o | output | 1 | Access is out of bounds; the consumer fills zero |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse after the last access |

## Verification
The checker assumes the three delta inputs hold values that match the configured extents, strides, dilations and mode, and that no configuration field changes during a run. Without those conditions the table-step property has no meaning. The bench recomputes the table for every configuration from the tensor strides before it issues a start, and it changes configuration only while the block is idle. The checker also assumes that R and S are at least 1 and that C is nonzero, and every configuration the bench uses meets this. Expected addresses come from the closed-form index arithmetic, not from accumulated deltas. This means a wrong table selection or a wrong wrap order appears as an address mismatch.

// File: rtl/igc_pkg.sv
package igc_pkg;

    parameter int unsigned IGC_DIM_W  = 8;
    parameter int unsigned IGC_IDX_W  = 16;
    parameter int unsigned IGC_ADDR_W = 32;

    // Which loop moved on a filter-position step; also the delta-table index.
    typedef enum logic [1:0] {
        STEP_S = 2'd0,
        STEP_R = 2'd1,
        STEP_C = 2'd2
    } step_e;

endpackage

// File: rtl/igc_row_decomp.sv
module igc_row_decomp #(
    parameter int unsigned DIM_W = 8,
    parameter int unsigned IDX_W = 16
) (
    input  logic [IDX_W-1:0] row_idx_i,
    input  logic [DIM_W-1:0] cfg_n_i,
    input  logic [DIM_W-1:0] cfg_p_i,
    input  logic [DIM_W-1:0] cfg_q_i,
    output logic [IDX_W-1:0] n_o,
    output logic [IDX_W-1:0] p_o,
    output logic [IDX_W-1:0] q_o,
    output logic             live_o
);

    logic [IDX_W-1:0] plane;
    logic [IDX_W-1:0] rem;

    // Done once per tile at start, so the divider sits off the per-access path.
    always_comb begin
        plane = IDX_W'(cfg_p_i) * IDX_W'(cfg_q_i);
        n_o   = '0;
        rem   = '0;
        p_o   = '0;
        q_o   = '0;
        if (plane != '0) begin
            n_o = row_idx_i / plane;
            rem = row_idx_i % plane;
        end
        if (cfg_q_i != '0) begin
            p_o = rem / IDX_W'(cfg_q_i);
            q_o = rem % IDX_W'(cfg_q_i);
        end
        live_o = (plane != '0) && (n_o < IDX_W'(cfg_n_i));
    end

endmodule

// File: rtl/igc_fpos.sv
module igc_fpos
    import igc_pkg::*;
#(
    parameter int unsigned DIM_W   = 8,
    parameter int unsigned IDX_W   = 16,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned CH_TILE = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     clear_i,
    input  logic                     step_i,
    input  logic [DIM_W-1:0]         cfg_r_i,
    input  logic [DIM_W-1:0]         cfg_s_i,
    input  logic [DIM_W-1:0]         cfg_c_i,
    input  logic [DIM_W-1:0]         cfg_split_i,
    input  logic [DIM_W-1:0]         cfg_dil_h_i,
    input  logic [DIM_W-1:0]         cfg_dil_w_i,
    input  logic                     cfg_conv_i,
    output step_e                    kind_o,
    output logic                     last_o,
    output logic [IDX_W-1:0]         chan_o,
    output logic signed [ADDR_W-1:0] hoff_o,
    output logic signed [ADDR_W-1:0] woff_o,
    output logic signed [ADDR_W-1:0] hoff_init_o,
    output logic signed [ADDR_W-1:0] woff_init_o
);

    typedef struct packed {
        logic [DIM_W-1:0]         s;
        logic [DIM_W-1:0]         r;
        logic [IDX_W-1:0]         c;
        logic signed [ADDR_W-1:0] hoff;
        logic signed [ADDR_W-1:0] woff;
    } fpos_t;

    fpos_t fp_d, fp_q;

    logic signed [ADDR_W-1:0] dh, dw, hmove, wmove;
    logic [IDX_W-1:0]         c_step;
    logic [IDX_W-1:0]         c_next;

    always_comb begin
        dh          = $signed(ADDR_W'(cfg_dil_h_i));
        dw          = $signed(ADDR_W'(cfg_dil_w_i));
        hmove       = cfg_conv_i ? -dh : dh;
        wmove       = cfg_conv_i ? -dw : dw;
        hoff_init_o = cfg_conv_i ? ($signed(ADDR_W'(cfg_r_i)) - 1) * dh : '0;
        woff_init_o = cfg_conv_i ? ($signed(ADDR_W'(cfg_s_i)) - 1) * dw : '0;
        c_step      = IDX_W'(CH_TILE) * IDX_W'(cfg_split_i);
        c_next      = fp_q.c + c_step;

        if ((fp_q.s + DIM_W'(1)) < cfg_s_i) begin
            kind_o = STEP_S;
        end else if ((fp_q.r + DIM_W'(1)) < cfg_r_i) begin
            kind_o = STEP_R;
        end else begin
            kind_o = STEP_C;
        end
        last_o = (kind_o == STEP_C) && (c_next >= IDX_W'(cfg_c_i));

        fp_d = fp_q;
        if (clear_i) begin
            fp_d.s    = '0;
            fp_d.r    = '0;
            fp_d.c    = '0;
            fp_d.hoff = hoff_init_o;
            fp_d.woff = woff_init_o;
        end else if (step_i) begin
            unique case (kind_o)
                STEP_S: begin
                    fp_d.s    = fp_q.s + DIM_W'(1);
                    fp_d.woff = fp_q.woff + wmove;
                end
                STEP_R: begin
                    fp_d.s    = '0;
                    fp_d.r    = fp_q.r + DIM_W'(1);
                    fp_d.woff = woff_init_o;
                    fp_d.hoff = fp_q.hoff + hmove;
                end
                default: begin
                    fp_d.s    = '0;
                    fp_d.r    = '0;
                    fp_d.c    = c_next;
                    fp_d.woff = woff_init_o;
                    fp_d.hoff = hoff_init_o;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fp_q <= '0;
        end else begin
            fp_q <= fp_d;
        end
    end

    assign chan_o = fp_q.c;
    assign hoff_o = fp_q.hoff;
    assign woff_o = fp_q.woff;

endmodule

// File: rtl/igc_row_track.sv
module igc_row_track #(
    parameter int unsigned DIM_W  = 8,
    parameter int unsigned IDX_W  = 16,
    parameter int unsigned ADDR_W = 32
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     load_i,
    input  logic                     step_i,
    input  logic signed [ADDR_W-1:0] delta_i,
    input  logic [IDX_W-1:0]         n_i,
    input  logic [IDX_W-1:0]         p_i,
    input  logic [IDX_W-1:0]         q_i,
    input  logic                     live_i,
    input  logic [DIM_W-1:0]         cfg_h_i,
    input  logic [DIM_W-1:0]         cfg_w_i,
    input  logic [DIM_W-1:0]         cfg_c_i,
    input  logic [DIM_W-1:0]         cfg_stride_h_i,
    input  logic [DIM_W-1:0]         cfg_stride_w_i,
    input  logic [DIM_W-1:0]         cfg_pad_h_i,
    input  logic [DIM_W-1:0]         cfg_pad_w_i,
    input  logic [DIM_W-1:0]         cfg_elem_bytes_i,
    input  logic signed [ADDR_W-1:0] cfg_base_i,
    input  logic signed [ADDR_W-1:0] hoff_init_i,
    input  logic signed [ADDR_W-1:0] woff_init_i,
    output logic signed [ADDR_W-1:0] hbase_o,
    output logic signed [ADDR_W-1:0] wbase_o,
    output logic                     live_o,
    output logic signed [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        logic signed [ADDR_W-1:0] hb;
        logic signed [ADDR_W-1:0] wb;
        logic                     live;
        logic signed [ADDR_W-1:0] addr;
    } row_t;

    row_t rw_d, rw_q;

    logic signed [ADDR_W-1:0] hb_new, wb_new, h0, w0, lin;

    always_comb begin
        hb_new = $signed(ADDR_W'(p_i)) * $signed(ADDR_W'(cfg_stride_h_i))
               - $signed(ADDR_W'(cfg_pad_h_i));
        wb_new = $signed(ADDR_W'(q_i)) * $signed(ADDR_W'(cfg_stride_w_i))
               - $signed(ADDR_W'(cfg_pad_w_i));
        h0     = hb_new + hoff_init_i;
        w0     = wb_new + woff_init_i;
        lin    = (($signed(ADDR_W'(n_i)) * $signed(ADDR_W'(cfg_h_i)) + h0)
                  * $signed(ADDR_W'(cfg_w_i)) + w0) * $signed(ADDR_W'(cfg_c_i));

        rw_d = rw_q;
        if (load_i) begin
            rw_d.hb   = hb_new;
            rw_d.wb   = wb_new;
            rw_d.live = live_i;
            rw_d.addr = cfg_base_i + lin * $signed(ADDR_W'(cfg_elem_bytes_i));
        end else if (step_i) begin
            // Position change: one table add, no multiply on this path.
            rw_d.addr = rw_q.addr + delta_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rw_q <= '0;
        end else begin
            rw_q <= rw_d;
        end
    end

    assign hbase_o = rw_q.hb;
    assign wbase_o = rw_q.wb;
    assign live_o  = rw_q.live;
    assign addr_o  = rw_q.addr;

endmodule

// File: rtl/igc_addr_gen.sv
module igc_addr_gen
    import igc_pkg::*;
#(
    parameter int unsigned ROWS   = 2,
    parameter int unsigned ACC_C  = 2,
    parameter int unsigned VEC    = 4,
    parameter int unsigned DIM_W  = IGC_DIM_W,
    parameter int unsigned IDX_W  = IGC_IDX_W,
    parameter int unsigned ADDR_W = IGC_ADDR_W
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic [DIM_W-1:0]         cfg_n_i,
    input  logic [DIM_W-1:0]         cfg_h_i,
    input  logic [DIM_W-1:0]         cfg_w_i,
    input  logic [DIM_W-1:0]         cfg_c_i,
    input  logic [DIM_W-1:0]         cfg_p_i,
    input  logic [DIM_W-1:0]         cfg_q_i,
    input  logic [DIM_W-1:0]         cfg_r_i,
    input  logic [DIM_W-1:0]         cfg_s_i,
    input  logic [DIM_W-1:0]         cfg_stride_h_i,
    input  logic [DIM_W-1:0]         cfg_stride_w_i,
    input  logic [DIM_W-1:0]         cfg_pad_h_i,
    input  logic [DIM_W-1:0]         cfg_pad_w_i,
    input  logic [DIM_W-1:0]         cfg_dil_h_i,
    input  logic [DIM_W-1:0]         cfg_dil_w_i,
    input  logic [DIM_W-1:0]         cfg_split_i,
    input  logic [DIM_W-1:0]         cfg_elem_bytes_i,
    input  logic                     cfg_conv_i,
    input  logic signed [ADDR_W-1:0] cfg_base_i,
    input  logic signed [ADDR_W-1:0] cfg_delta_s_i,
    input  logic signed [ADDR_W-1:0] cfg_delta_r_i,
    input  logic signed [ADDR_W-1:0] cfg_delta_c_i,
    input  logic                     start_i,
    input  logic [IDX_W-1:0]         start_row_i,
    output logic                     acc_vld_o,
    output logic signed [ADDR_W-1:0] acc_addr_o,
    output logic                     acc_zero_o,
    output logic                     busy_o,
    output logic                     done_o
);

    localparam int unsigned CH_TILE = ACC_C * VEC;
    localparam int unsigned SIDX_W  = (ROWS  > 1) ? $clog2(ROWS)  : 1;
    localparam int unsigned CIDX_W  = (ACC_C > 1) ? $clog2(ACC_C) : 1;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [SIDX_W-1:0] sidx;
        logic [CIDX_W-1:0] cidx;
    } seq_t;

    seq_t sq_d, sq_q;

    logic                     take;
    logic                     adv;
    step_e                    kind;
    logic                     last;
    logic [IDX_W-1:0]         chan;
    logic signed [ADDR_W-1:0] hoff, woff, hoff_init, woff_init;
    logic signed [ADDR_W-1:0] delta_sel;

    logic [IDX_W-1:0]         dc_n    [ROWS];
    logic [IDX_W-1:0]         dc_p    [ROWS];
    logic [IDX_W-1:0]         dc_q    [ROWS];
    logic                     dc_live [ROWS];
    logic signed [ADDR_W-1:0] rw_hb   [ROWS];
    logic signed [ADDR_W-1:0] rw_wb   [ROWS];
    logic                     rw_live [ROWS];
    logic signed [ADDR_W-1:0] rw_addr [ROWS];

    igc_fpos #(
        .DIM_W  (DIM_W),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W),
        .CH_TILE(CH_TILE)
    ) u_fpos (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .clear_i    (take),
        .step_i     (adv),
        .cfg_r_i    (cfg_r_i),
        .cfg_s_i    (cfg_s_i),
        .cfg_c_i    (cfg_c_i),
        .cfg_split_i(cfg_split_i),
        .cfg_dil_h_i(cfg_dil_h_i),
        .cfg_dil_w_i(cfg_dil_w_i),
        .cfg_conv_i (cfg_conv_i),
        .kind_o     (kind),
        .last_o     (last),
        .chan_o     (chan),
        .hoff_o     (hoff),
        .woff_o     (woff),
        .hoff_init_o(hoff_init),
        .woff_init_o(woff_init)
    );

    always_comb begin
        unique case (kind)
            STEP_S:  delta_sel = cfg_delta_s_i;
            STEP_R:  delta_sel = cfg_delta_r_i;
            default: delta_sel = cfg_delta_c_i;
        endcase
    end

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        igc_row_decomp #(
            .DIM_W(DIM_W),
            .IDX_W(IDX_W)
        ) u_decomp (
            .row_idx_i(start_row_i + IDX_W'(g)),
            .cfg_n_i  (cfg_n_i),
            .cfg_p_i  (cfg_p_i),
            .cfg_q_i  (cfg_q_i),
            .n_o      (dc_n[g]),
            .p_o      (dc_p[g]),
            .q_o      (dc_q[g]),
            .live_o   (dc_live[g])
        );

        igc_row_track #(
            .DIM_W (DIM_W),
            .IDX_W (IDX_W),
            .ADDR_W(ADDR_W)
        ) u_track (
            .clk_i           (clk_i),
            .rst_i           (rst_i),
            .load_i          (take),
            .step_i          (adv),
            .delta_i         (delta_sel),
            .n_i             (dc_n[g]),
            .p_i             (dc_p[g]),
            .q_i             (dc_q[g]),
            .live_i          (dc_live[g]),
            .cfg_h_i         (cfg_h_i),
            .cfg_w_i         (cfg_w_i),
            .cfg_c_i         (cfg_c_i),
            .cfg_stride_h_i  (cfg_stride_h_i),
            .cfg_stride_w_i  (cfg_stride_w_i),
            .cfg_pad_h_i     (cfg_pad_h_i),
            .cfg_pad_w_i     (cfg_pad_w_i),
            .cfg_elem_bytes_i(cfg_elem_bytes_i),
            .cfg_base_i      (cfg_base_i),
            .hoff_init_i     (hoff_init),
            .woff_init_i     (woff_init),
            .hbase_o         (rw_hb[g]),
            .wbase_o         (rw_wb[g]),
            .live_o          (rw_live[g]),
            .addr_o          (rw_addr[g])
        );
    end

    // Sequencer: chunk index fastest, then row slot, then filter position.
    always_comb begin
        take = start_i && !sq_q.busy;
        adv  = 1'b0;
        sq_d = sq_q;
        sq_d.done = 1'b0;
        if (take) begin
            sq_d.busy = 1'b1;
            sq_d.sidx = '0;
            sq_d.cidx = '0;
        end else if (sq_q.busy) begin
            if (sq_q.cidx == CIDX_W'(ACC_C - 1)) begin
                sq_d.cidx = '0;
                if (sq_q.sidx == SIDX_W'(ROWS - 1)) begin
                    sq_d.sidx = '0;
                    adv       = 1'b1;
                    if (last) begin
                        sq_d.busy = 1'b0;
                        sq_d.done = 1'b1;
                    end
                end else begin
                    sq_d.sidx = sq_q.sidx + SIDX_W'(1);
                end
            end else begin
                sq_d.cidx = sq_q.cidx + CIDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    logic signed [ADDR_W-1:0] cur_h, cur_w, chunk_bytes;
    logic [IDX_W-1:0]         cur_ch;
    logic                     in_bounds;

    always_comb begin
        cur_h       = rw_hb[sq_q.sidx] + hoff;
        cur_w       = rw_wb[sq_q.sidx] + woff;
        cur_ch      = chan + IDX_W'(sq_q.cidx) * IDX_W'(VEC);
        chunk_bytes = $signed(ADDR_W'(sq_q.cidx)) * $signed(ADDR_W'(VEC))
                    * $signed(ADDR_W'(cfg_elem_bytes_i));
        in_bounds   = rw_live[sq_q.sidx]
                   && (cur_h >= 0) && (cur_h < $signed(ADDR_W'(cfg_h_i)))
                   && (cur_w >= 0) && (cur_w < $signed(ADDR_W'(cfg_w_i)))
                   && (cur_ch < IDX_W'(cfg_c_i));
    end

    assign acc_vld_o  = sq_q.busy;
    assign acc_addr_o = rw_addr[sq_q.sidx] + chunk_bytes;
    assign acc_zero_o = sq_q.busy && !in_bounds;
    assign busy_o     = sq_q.busy;
    assign done_o     = sq_q.done;

endmodule

// File: rtl/igc_addr_gen_chk.sv
module igc_addr_gen_chk #(
    parameter int unsigned ROWS   = 2,
    parameter int unsigned ACC_C  = 2,
    parameter int unsigned DIM_W  = 8,
    parameter int unsigned ADDR_W = 32
) (
    input logic                     clk_i,
    input logic                     rst_i,
    input logic                     start_i,
    input logic [DIM_W-1:0]         cfg_r_i,
    input logic [DIM_W-1:0]         cfg_s_i,
    input logic signed [ADDR_W-1:0] cfg_delta_s_i,
    input logic signed [ADDR_W-1:0] cfg_delta_r_i,
    input logic signed [ADDR_W-1:0] cfg_delta_c_i,
    input logic                     acc_vld_o,
    input logic signed [ADDR_W-1:0] acc_addr_o,
    input logic                     acc_zero_o,
    input logic                     busy_o,
    input logic                     done_o
);

    localparam int unsigned PER_POS = ROWS * ACC_C;
    localparam int unsigned CNT_W   = (PER_POS > 1) ? $clog2(PER_POS) : 1;

    // Independent position model: counts accesses, predicts the next anchor address.
    logic [CNT_W-1:0]         m_cnt;
    logic [DIM_W-1:0]         m_s, m_r;
    logic                     m_have;
    logic signed [ADDR_W-1:0] m_anchor, m_expect, m_cur0, m_delta;

    always_comb begin
        m_cur0 = (m_cnt == '0) ? acc_addr_o : m_anchor;
        if ((m_s + DIM_W'(1)) < cfg_s_i) begin
            m_delta = cfg_delta_s_i;
        end else if ((m_r + DIM_W'(1)) < cfg_r_i) begin
            m_delta = cfg_delta_r_i;
        end else begin
            m_delta = cfg_delta_c_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            m_cnt    <= '0;
            m_s      <= '0;
            m_r      <= '0;
            m_have   <= 1'b0;
            m_anchor <= '0;
            m_expect <= '0;
        end else if (start_i && !busy_o) begin
            m_cnt  <= '0;
            m_s    <= '0;
            m_r    <= '0;
            m_have <= 1'b0;
        end else if (acc_vld_o) begin
            if (m_cnt == '0) begin
                m_anchor <= acc_addr_o;
            end
            if (m_cnt == CNT_W'(PER_POS - 1)) begin
                m_cnt    <= '0;
                m_have   <= 1'b1;
                m_expect <= m_cur0 + m_delta;
                if ((m_s + DIM_W'(1)) < cfg_s_i) begin
                    m_s <= m_s + DIM_W'(1);
                end else begin
                    m_s <= '0;
                    m_r <= ((m_r + DIM_W'(1)) < cfg_r_i) ? m_r + DIM_W'(1) : '0;
                end
            end else begin
                m_cnt <= m_cnt + CNT_W'(1);
            end
        end
    end

    assert_delta_step_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_vld_o && m_have && (m_cnt == '0)) |-> (acc_addr_o == m_expect));

    assert_zero_needs_vld_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        acc_zero_o |-> acc_vld_o);

    assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (!busy_o && !acc_vld_o));

    assert_done_after_run_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |-> done_o);

    assert_start_accept_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !busy_o) |=> busy_o);

    assert_vld_origin_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(acc_vld_o) |-> $past(start_i));

endmodule

bind igc_addr_gen igc_addr_gen_chk #(
    .ROWS  (ROWS),
    .ACC_C (ACC_C),
    .DIM_W (DIM_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .start_i      (start_i),
    .cfg_r_i      (cfg_r_i),
    .cfg_s_i      (cfg_s_i),
    .cfg_delta_s_i(cfg_delta_s_i),
    .cfg_delta_r_i(cfg_delta_r_i),
    .cfg_delta_c_i(cfg_delta_c_i),
    .acc_vld_o    (acc_vld_o),
    .acc_addr_o   (acc_addr_o),
    .acc_zero_o   (acc_zero_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/tb_igc_addr_gen.sv
module tb_igc_addr_gen;

    localparam int ROWS  = 2;
    localparam int ACC_C = 2;
    localparam int VEC   = 4;
    localparam int TILE  = ROWS * 0 + ACC_C * VEC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int cN, cH, cW, cC, cP, cQ, cR, cS, cSh, cSw, cPh, cPw, cDh, cDw, cSplit, cEb, cBase;
    bit cConv;
    int d0, d1, d2;

    logic        start = 1'b0;
    logic [15:0] start_row = '0;
    logic        acc_vld, acc_zero, busy, done;
    logic signed [31:0] acc_addr;

    igc_addr_gen #(.ROWS(ROWS), .ACC_C(ACC_C), .VEC(VEC)) dut (
        .clk_i(clk), .rst_i(rst),
        .cfg_n_i(8'(cN)), .cfg_h_i(8'(cH)), .cfg_w_i(8'(cW)), .cfg_c_i(8'(cC)),
        .cfg_p_i(8'(cP)), .cfg_q_i(8'(cQ)), .cfg_r_i(8'(cR)), .cfg_s_i(8'(cS)),
        .cfg_stride_h_i(8'(cSh)), .cfg_stride_w_i(8'(cSw)),
        .cfg_pad_h_i(8'(cPh)), .cfg_pad_w_i(8'(cPw)),
        .cfg_dil_h_i(8'(cDh)), .cfg_dil_w_i(8'(cDw)),
        .cfg_split_i(8'(cSplit)), .cfg_elem_bytes_i(8'(cEb)), .cfg_conv_i(cConv),
        .cfg_base_i(cBase), .cfg_delta_s_i(d0), .cfg_delta_r_i(d1), .cfg_delta_c_i(d2),
        .start_i(start), .start_row_i(start_row),
        .acc_vld_o(acc_vld), .acc_addr_o(acc_addr), .acc_zero_o(acc_zero),
        .busy_o(busy), .done_o(done)
    );

    int tests = 0;
    int fails = 0;
    int exp_addr [0:1023];
    bit exp_zero [0:1023];
    int nexp;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Delta table from tensor strides (W-stride = C, H-stride = W*C elements).
    task automatic load_table();
        int sg = cConv ? -1 : 1;
        int ws = cC;
        int hs = cW * cC;
        d0 = sg * ws * cDw * cEb;
        d1 = sg * (hs * cDh - (cS - 1) * ws * cDw) * cEb;
        d2 = (TILE * cSplit - sg * (cR - 1) * hs * cDh - sg * (cS - 1) * ws * cDw) * cEb;
    endtask

    // Closed-form expected stream: c, then r, then s, then row slot, then chunk.
    task automatic build_exp(input int i0);
        nexp = 0;
        for (int c = 0; c < cC; c += TILE * cSplit)
            for (int r = 0; r < cR; r++)
                for (int s = 0; s < cS; s++)
                    for (int j = 0; j < ROWS; j++)
                        for (int k = 0; k < ACC_C; k++) begin
                            int i  = i0 + j;
                            int n  = i / (cP * cQ);
                            int rm = i % (cP * cQ);
                            int p  = rm / cQ;
                            int q  = rm % cQ;
                            int rr = cConv ? cR - 1 - r : r;
                            int ss = cConv ? cS - 1 - s : s;
                            int h  = p * cSh - cPh + rr * cDh;
                            int w  = q * cSw - cPw + ss * cDw;
                            int ch = c + k * VEC;
                            exp_addr[nexp] = cBase + (((n * cH + h) * cW + w) * cC + ch) * cEb;
                            exp_zero[nexp] = !(n < cN && h >= 0 && h < cH && w >= 0 && w < cW && ch < cC);
                            nexp++;
                        end
    endtask

    task automatic run_case(input int i0, input string tag, input bit poke);
        int per_pos = ROWS * ACC_C;
        load_table();
        build_exp(i0);
        @(negedge clk);
        start = 1'b1;
        start_row = 16'(i0);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < nexp; k++) begin
            string t;
            if (poke) t = "R9";
            else if (k < per_pos) t = "R2";
            else if ((k % per_pos) == 0) t = "R7";
            else t = tag;
            chk(acc_vld == 1'b1, "R10", acc_vld, 1);
            chk(acc_addr == exp_addr[k], t, acc_addr, exp_addr[k]);
            chk(acc_zero == exp_zero[k], "R6", acc_zero, exp_zero[k]);
            if (poke && k == 3) begin
                start = 1'b1;
                start_row = 16'(i0 + 7);
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk(done == 1'b1, "R8", done, 1);
        chk(busy == 1'b0, "R8", busy, 0);
        chk(acc_vld == 1'b0, "R8", acc_vld, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8", done, 0);
    endtask

    initial begin
        cN = 2; cH = 4; cW = 4; cC = 12; cP = 4; cQ = 4; cR = 3; cS = 3;
        cSh = 1; cSw = 1; cPh = 1; cPw = 1; cDh = 1; cDw = 1;
        cSplit = 1; cEb = 1; cBase = 1000; cConv = 1'b0;
        load_table();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        chk(acc_vld == 1'b0, "R1", acc_vld, 0);
        chk(busy == 1'b0, "R1", busy, 0);
        chk(done == 1'b0, "R1", done, 0);
        chk(acc_zero == 1'b0, "R1", acc_zero, 0);

        // Cross-correlation, padding on all sides, partial last channel chunk.
        run_case(0, "R3", 1'b0);
        run_case(31, "R6", 1'b0);   // second row slot lies past the batch
        run_case(13, "R4", 1'b1);   // start while busy must be ignored

        // Flipped filter, stride 2, dilation 2, 2-byte elements.
        cN = 1; cH = 6; cW = 5; cC = 8; cP = 3; cQ = 3; cR = 2; cS = 3;
        cSh = 2; cSw = 1; cPh = 1; cPw = 2; cDh = 2; cDw = 1;
        cSplit = 1; cEb = 2; cBase = 64; cConv = 1'b1;
        run_case(4, "R5", 1'b0);
        run_case(7, "R5", 1'b0);

        // Split reduction: channel step doubles; R = 1 forces r-wrap every s-wrap.
        cN = 1; cH = 3; cW = 3; cC = 20; cP = 3; cQ = 2; cR = 1; cS = 2;
        cSh = 1; cSw = 1; cPh = 0; cPw = 0; cDh = 1; cDw = 1;
        cSplit = 2; cEb = 4; cBase = 0; cConv = 1'b0;
        run_case(2, "R3", 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule